// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, holds them in a request register, and filters them through a mask register. It raises a single interrupt line toward the processor when an unmasked request outranks everything already in service. Priority is fixed, with input 0 highest. When the processor acknowledges, the block moves the winning request into the in-service register. One cycle later it delivers an 8-bit vector. The upper five bits of the vector are a programmed base and the lower three bits are the winning input number.

Software programs the block through a byte-wide port with two addresses, control and data. A control write with bit 4 set starts a fixed initialization sequence. After that sequence, data-address accesses reach the mask register. Control writes then issue a non-specific end-of-interrupt or choose which status register a control read returns.

Two instances can be chained so that one serves as the primary and one as the secondary, giving sixteen inputs. The secondary's interrupt output drives one input of the primary. When the primary acknowledges that input, it announces the input number on a cascade bus instead of driving its own vector. Only the secondary whose programmed identity matches that number answers with its vector.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, intReq and vecValid are 0, a data-address read returns the mask as 0xFF, and a control-address read returns the request register as 0x00.
- R2: A control write with bit 4 set begins initialization and clears the mask, the in-service register and the request register. It also selects request-register readback. In that first word, bit 0 means a mode word will follow, bit 1 means single (no cascade) and bit 3 means level triggering. The data writes that follow are taken in order as the vector base, then the cascade word (skipped when single), then the mode word (skipped when bit 0 was 0). Every later data write loads the mask.
- R3: One cycle after the acknowledge cycle, vecValid is 1 for exactly one cycle. vecOut then equals the upper five bits of the base word joined to the 3-bit index of the winning input.
- R4: A set mask bit keeps its input from raising intReq, while the request still stays visible in the request register. Clearing the mask bit lets that request raise intReq.
- R5: Among several pending unmasked requests, the lowest-numbered input wins the acknowledge.
- R6: intReq rises only for an unmasked request whose input number is strictly lower than every set in-service bit. A request of equal or lower priority waits, and a higher one preempts and nests.
- R7: A control write of 0x20 clears only the lowest-numbered set bit of the in-service register.
- R8: After a control write of 0x0A, control reads return the request register. After 0x0B, they return the in-service register. Data reads always return the mask.
- R9: In edge mode, a request bit is set by a rising input and cleared by its acknowledge, and an input held high does not set it again. In level mode, the request bit follows the input each cycle.
- R10: When bit 1 of the mode word is set (automatic end-of-interrupt), an acknowledge delivers the vector but leaves the in-service register unchanged.
- R11: A primary (roleIsPrimary=1, cascaded) holds a cascade-word bit set for each input that carries a secondary. When it acknowledges such an input, it drives casOutValid=1 and casOut set to that input number during the acknowledge cycle, and it raises no vecValid of its own. A secondary answers an acknowledge only when casInValid is 1 and casIn equals the low three bits of its cascade word.
- R12: An acknowledge with no eligible request delivers the base joined to index 7 and changes neither the request nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| roleIsPrimary | input | 1 | 1 for the primary unit of a cascaded pair |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 selects the control address, 1 selects the data address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the current busAddr |
| irqReq | input | 8 | Interrupt request inputs |
| intReq | output | 1 | Interrupt line to the processor |
| ackIn | input | 1 | One-cycle interrupt acknowledge |
| vecOut | output | 8 | Delivered vector |
| vecValid | output | 1 | vecOut is valid this cycle |
| casOut | output | 3 | Cascade input number announced by a primary |
| casOutValid | output | 1 | casOut is being driven |
| casIn | input | 3 | Cascade input number seen by a secondary |
| casInValid | input | 1 | casIn is valid |

## Verification
The hardest situation to reach is a secondary request that travels through a masked cascade input on the primary. In that case the primary's request bit latches even though intReq stays low, and the secondary must stay silent while the primary acknowledges some other input. The bench masks the primary's cascade input and raises a secondary line and a primary line together. It then acknowledges and checks that only the primary responds and the secondary's in-service register stays empty. After that it unmasks the cascade input and shows that the latched request is now routed to the secondary's vector.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int DATA_W = 8;
  localparam int LINES = DATA_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int BASE_W = DATA_W - IDX_W;
  localparam int INIT_BIT = 4;
  localparam logic [DATA_W-1:0] CMD_EOI = 8'h20;
  localparam logic [DATA_W-1:0] CMD_SHOW_IRR = 8'h0A;
  localparam logic [DATA_W-1:0] CMD_SHOW_ISR = 8'h0B;

  typedef enum logic [1:0] {
    ST_READY,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } initState_t;

  typedef struct packed {
    logic initClr;
    logic eoi;
    logic maskWr;
  } dpStrobe_t;

  typedef struct packed {
    logic levelMode;
    logic autoEoi;
    logic single;
    logic [BASE_W-1:0] vecBase;
    logic [LINES-1:0] casMap;
    logic showIsr;
    logic ready;
  } cfg_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output dpStrobe_t         strobe,
  output cfg_t              cfg
);
  initState_t state;
  logic wantMode;
  logic levelMode, autoEoi, single, showIsr;
  logic [BASE_W-1:0] vecBase;
  logic [LINES-1:0] casMap;

  logic ctrlWr, dataWr, startInit, isReady;
  assign ctrlWr    = busWr & ~busAddr;
  assign dataWr    = busWr & busAddr;
  assign startInit = ctrlWr & busWrData[INIT_BIT];
  assign isReady   = (state == ST_READY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_READY;
      wantMode  <= 1'b0;
      levelMode <= 1'b0;
      autoEoi   <= 1'b0;
      single    <= 1'b1;
      showIsr   <= 1'b0;
      vecBase   <= '0;
      casMap    <= '0;
    end else if (startInit) begin
      state     <= ST_BASE;
      wantMode  <= busWrData[0];
      single    <= busWrData[1];
      levelMode <= busWrData[3];
      autoEoi   <= 1'b0;
      showIsr   <= 1'b0;
    end else begin
      unique case (state)
        ST_BASE: if (dataWr) begin
          vecBase <= busWrData[DATA_W-1:IDX_W];
          if (!single) state <= ST_CASC;
          else state <= wantMode ? ST_MODE : ST_READY;
        end
        ST_CASC: if (dataWr) begin
          casMap <= busWrData;
          state  <= wantMode ? ST_MODE : ST_READY;
        end
        ST_MODE: if (dataWr) begin
          autoEoi <= busWrData[1];
          state   <= ST_READY;
        end
        default: if (ctrlWr) begin
          if (busWrData == CMD_SHOW_IRR) showIsr <= 1'b0;
          else if (busWrData == CMD_SHOW_ISR) showIsr <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.initClr = startInit;
    strobe.eoi     = isReady & ctrlWr & (busWrData == CMD_EOI);
    strobe.maskWr  = isReady & dataWr;
    cfg.levelMode  = levelMode;
    cfg.autoEoi    = autoEoi;
    cfg.single     = single;
    cfg.vecBase    = vecBase;
    cfg.casMap     = casMap;
    cfg.showIsr    = showIsr;
    cfg.ready      = isReady;
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              roleIsPrimary,
  input  logic [DATA_W-1:0] busWrData,
  input  dpStrobe_t         strobe,
  input  cfg_t              cfg,
  input  logic [LINES-1:0]  irqReq,
  input  logic              ackIn,
  input  logic [IDX_W-1:0]  casIn,
  input  logic              casInValid,
  output logic              intReq,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic [IDX_W-1:0]  casOut,
  output logic              casOutValid,
  output logic [LINES-1:0]  irrQ,
  output logic [LINES-1:0]  isrQ,
  output logic [LINES-1:0]  maskQ
);
  logic [LINES-1:0] irqPrev, irr, isr, mask;
  logic [LINES-1:0] allowed, cand, winHot, isrLowHot, irrNext, setIsr, clrIsr;
  logic [IDX_W-1:0] winIdx;
  logic anyCand, casMatch, respond, toSecondary, take;

  // an input may interrupt only if no in-service bit sits at or above it
  for (genvar g = 0; g < LINES; g++) begin : g_allow
    assign allowed[g] = ~|isr[g:0];
  end

  assign cand    = irr & ~mask & allowed;
  assign anyCand = |cand;

  always_comb begin
    winIdx = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (cand[k]) winIdx = IDX_W'(k);
    end
  end

  assign winHot      = anyCand ? (LINES'(1) << winIdx) : '0;
  assign isrLowHot   = isr & (~isr + LINES'(1));
  assign casMatch    = casInValid && (casIn == cfg.casMap[IDX_W-1:0]);
  assign respond     = ackIn && (cfg.single || roleIsPrimary || casMatch);
  assign toSecondary = roleIsPrimary && !cfg.single && anyCand && cfg.casMap[winIdx];
  assign take        = respond && anyCand;
  assign casOutValid = ackIn && toSecondary;
  assign casOut      = casOutValid ? winIdx : '0;

  assign irrNext = cfg.levelMode ? irqReq
                 : ((irr & ~(take ? winHot : '0)) | (irqReq & ~irqPrev));
  assign setIsr  = (take && !cfg.autoEoi) ? winHot : '0;
  assign clrIsr  = strobe.eoi ? isrLowHot : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      irr      <= '0;
      isr      <= '0;
      mask     <= '1;
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      irqPrev  <= irqReq;
      vecValid <= respond && !toSecondary;
      if (respond && !toSecondary)
        vecOut <= {cfg.vecBase, anyCand ? winIdx : {IDX_W{1'b1}}};
      if (strobe.initClr) begin
        irr  <= '0;
        isr  <= '0;
        mask <= '0;
      end else begin
        irr <= irrNext;
        isr <= (isr & ~clrIsr) | setIsr;
        if (strobe.maskWr) mask <= busWrData;
      end
    end
  end

  assign intReq = anyCand;
  assign irrQ   = irr;
  assign isrQ   = isr;
  assign maskQ  = mask;
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              roleIsPrimary,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [LINES-1:0]  irqReq,
  output logic              intReq,
  input  logic              ackIn,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic [IDX_W-1:0]  casOut,
  output logic              casOutValid,
  input  logic [IDX_W-1:0]  casIn,
  input  logic              casInValid
);
  dpStrobe_t strobe;
  cfg_t cfg;
  logic [LINES-1:0] irrQ, isrQ, maskQ;
  logic cfgReady;

  irq_prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .strobe(strobe), .cfg(cfg)
  );

  irq_prio_dp u_dp (
    .clk(clk), .rstN(rstN), .roleIsPrimary(roleIsPrimary), .busWrData(busWrData),
    .strobe(strobe), .cfg(cfg), .irqReq(irqReq), .ackIn(ackIn),
    .casIn(casIn), .casInValid(casInValid), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid), .casOut(casOut),
    .casOutValid(casOutValid), .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ)
  );

  assign cfgReady  = cfg.ready;
  assign busRdData = busAddr ? maskQ : (cfg.showIsr ? isrQ : irrQ);
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk
  import irq_prio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              roleIsPrimary,
  input logic              busWr,
  input logic              busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              ackIn,
  input logic              intReq,
  input logic              vecValid,
  input logic              casOutValid,
  input logic [LINES-1:0]  irrQ,
  input logic [LINES-1:0]  isrQ,
  input logic [LINES-1:0]  maskQ,
  input logic              cfgReady
);
  assert_vec_follows_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackIn));

  assert_cas_only_primary_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    casOutValid |-> (ackIn && roleIsPrimary));

  assert_int_needs_unmasked_R4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((irrQ & ~maskQ) != '0));

  assert_isr_grows_by_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(isrQ) > 0) |-> ($countones(isrQ) <= $countones($past(isrQ)) + 1));

  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && busWrData[INIT_BIT]) |=> (maskQ == '0 && isrQ == '0 && irrQ == '0));

  assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && busWrData == CMD_EOI && cfgReady && !ackIn)
      |=> ($countones(isrQ) + (($past(isrQ) != '0) ? 1 : 0) == $countones($past(isrQ))));
endmodule

bind irq_prio_unit irq_prio_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .roleIsPrimary(roleIsPrimary), .busWr(busWr),
  .busAddr(busAddr), .busWrData(busWrData), .ackIn(ackIn), .intReq(intReq),
  .vecValid(vecValid), .casOutValid(casOutValid), .irrQ(irrQ), .isrQ(isrQ),
  .maskQ(maskQ), .cfgReady(cfgReady)
);

// File: tb/sim_irq_prio_unit.sv
module sim_irq_prio_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic bw0 = 0, bw1 = 0, bAddr = 0, ack = 0;
  logic [7:0] bData = 0, irq0 = 0, irq1 = 0;
  logic [7:0] rd0, rd1, vec0, vec1;
  logic int0, int1, vv0, vv1, cov0, cov1;
  logic [2:0] cas0, cas1;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_prio_unit u0 (
    .clk(clk), .rstN(rstN), .roleIsPrimary(1'b1), .busWr(bw0), .busAddr(bAddr),
    .busWrData(bData), .busRdData(rd0), .irqReq({irq0[7:3], int1, irq0[1:0]}),
    .intReq(int0), .ackIn(ack), .vecOut(vec0), .vecValid(vv0), .casOut(cas0),
    .casOutValid(cov0), .casIn(3'd0), .casInValid(1'b0)
  );

  irq_prio_unit u1 (
    .clk(clk), .rstN(rstN), .roleIsPrimary(1'b0), .busWr(bw1), .busAddr(bAddr),
    .busWrData(bData), .busRdData(rd1), .irqReq(irq1), .intReq(int1), .ackIn(ack),
    .vecOut(vec1), .vecValid(vv1), .casOut(cas1), .casOutValid(cov1),
    .casIn(cas0), .casInValid(cov0)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int u, input logic a, input logic [7:0] d);
    @(negedge clk);
    bAddr = a; bData = d;
    if (u == 0) bw0 = 1; else bw1 = 1;
    @(negedge clk);
    bw0 = 0; bw1 = 0;
  endtask

  task automatic rd(input int u, input logic a, output logic [7:0] v);
    @(negedge clk);
    bAddr = a;
    #1 v = (u == 0) ? rd0 : rd1;
  endtask

  task automatic rdIrr(input int u, output logic [7:0] v);
    wr(u, 0, 8'h0A); rd(u, 0, v);
  endtask

  task automatic rdIsr(input int u, output logic [7:0] v);
    wr(u, 0, 8'h0B); rd(u, 0, v);
  endtask

  task automatic doAck(output logic cv, output logic [2:0] co, output logic v0,
                       output logic v1, output logic [7:0] vec);
    @(negedge clk);
    ack = 1;
    #1 cv = cov0; co = cas0;
    @(negedge clk);
    ack = 0;
    #1 v0 = vv0; v1 = vv1; vec = vv0 ? vec0 : vec1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic eoi(input int u);
    wr(u, 0, 8'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, vec;
    logic cv, v0, v1;
    logic [2:0] co;

    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    rd(0, 1, v); chk("R1 mask after reset", v, 8'hFF);
    rd(0, 0, v); chk("R1 request readback after reset", v, 8'h00);
    chk("R1 intReq after reset", {7'd0, int0}, 8'd0);
    chk("R1 vecValid after reset", {7'd0, vv0}, 8'd0);

    // R2: cascaded pair, edge mode, mode word present
    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    rd(0, 1, v); chk("R2 mask cleared by first word", v, 8'h00);
    wr(0, 1, 8'h5A); rd(0, 1, v); chk("R2 data write after sequence loads mask", v, 8'h5A);
    wr(0, 1, 8'h00); wr(1, 1, 8'h00);

    // R3/R8/R9: sweep every primary input
    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      @(negedge clk) irq0[i] = 1;
      settle();
      chk($sformatf("R3 intReq input %0d", i), {7'd0, int0}, 8'd1);
      doAck(cv, co, v0, v1, vec);
      chk($sformatf("R3 vector input %0d", i), vec, 8'h20 + 8'(i));
      chk($sformatf("R11 no cascade for input %0d", i), {7'd0, cv}, 8'd0);
      rdIsr(0, v); chk($sformatf("R8 in-service input %0d", i), v, 8'(1 << i));
      rdIrr(0, v); chk($sformatf("R9 held input %0d not relatched", i), v, 8'h00);
      eoi(0);
      rdIsr(0, v); chk($sformatf("R7 eoi input %0d", i), v, 8'h00);
      @(negedge clk) irq0[i] = 0;
    end

    // R11: sweep every secondary input
    for (int j = 0; j < 8; j++) begin
      @(negedge clk) irq1[j] = 1;
      settle();
      doAck(cv, co, v0, v1, vec);
      chk($sformatf("R11 cascade strobe sec %0d", j), {7'd0, cv}, 8'd1);
      chk($sformatf("R11 cascade number sec %0d", j), {5'd0, co}, 8'd2);
      chk($sformatf("R11 primary silent sec %0d", j), {7'd0, v0}, 8'd0);
      chk($sformatf("R3 secondary vector %0d", j), vec, 8'h28 + 8'(j));
      rdIsr(0, v); chk($sformatf("R8 primary in-service sec %0d", j), v, 8'h04);
      eoi(1); eoi(0);
      @(negedge clk) irq1[j] = 0;
    end

    // R4: masking each primary input
    for (int i = 0; i < 8; i++) begin
      if (i == 2) continue;
      wr(0, 1, 8'(1 << i));
      @(negedge clk) irq0[i] = 1;
      settle();
      chk($sformatf("R4 masked input %0d quiet", i), {7'd0, int0}, 8'd0);
      rdIrr(0, v); chk($sformatf("R4 masked input %0d still requested", i), v, 8'(1 << i));
      wr(0, 1, 8'h00);
      #1 chk($sformatf("R4 unmasked input %0d raises", i), {7'd0, int0}, 8'd1);
      doAck(cv, co, v0, v1, vec);
      chk($sformatf("R4 vector input %0d", i), vec, 8'h20 + 8'(i));
      eoi(0);
      @(negedge clk) irq0[i] = 0;
    end

    // R5: every pair of primary inputs raised together
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        if (a == 2 || b == 2) continue;
        @(negedge clk) begin irq0[a] = 1; irq0[b] = 1; end
        settle();
        doAck(cv, co, v0, v1, vec);
        chk($sformatf("R5 pair %0d/%0d first", a, b), vec, 8'h20 + 8'(a));
        eoi(0);
        doAck(cv, co, v0, v1, vec);
        chk($sformatf("R5 pair %0d/%0d second", a, b), vec, 8'h20 + 8'(b));
        eoi(0);
        @(negedge clk) begin irq0[a] = 0; irq0[b] = 0; end
      end
    end

    // R6/R7: nesting and preemption
    @(negedge clk) irq0[5] = 1;
    settle();
    doAck(cv, co, v0, v1, vec); chk("R6 first level", vec, 8'h25);
    @(negedge clk) irq0[6] = 1;
    settle();
    chk("R6 lower priority waits", {7'd0, int0}, 8'd0);
    @(negedge clk) irq0[3] = 1;
    settle();
    chk("R6 higher priority raises", {7'd0, int0}, 8'd1);
    doAck(cv, co, v0, v1, vec); chk("R6 preempting vector", vec, 8'h23);
    rdIsr(0, v); chk("R6 nested in-service", v, 8'h28);
    eoi(0);
    rdIsr(0, v); chk("R7 eoi clears highest priority only", v, 8'h20);
    chk("R6 still blocked by level 5", {7'd0, int0}, 8'd0);
    eoi(0);
    #1 chk("R6 released after eoi", {7'd0, int0}, 8'd1);
    doAck(cv, co, v0, v1, vec); chk("R6 waiting vector", vec, 8'h26);
    eoi(0);
    @(negedge clk) begin irq0[3] = 0; irq0[5] = 0; irq0[6] = 0; end
    @(negedge clk) irq0[4] = 1;
    settle();
    doAck(cv, co, v0, v1, vec); chk("R6 equal level first", vec, 8'h24);
    @(negedge clk) irq0[4] = 0;
    @(negedge clk) irq0[4] = 1;
    settle();
    chk("R6 equal priority waits", {7'd0, int0}, 8'd0);
    eoi(0);
    #1 chk("R6 equal priority after eoi", {7'd0, int0}, 8'd1);
    doAck(cv, co, v0, v1, vec); chk("R6 equal level second", vec, 8'h24);
    eoi(0);
    @(negedge clk) irq0[4] = 0;

    // R11: cascade input masked, secondary must stay silent
    wr(0, 1, 8'h04);
    @(negedge clk) begin irq1[3] = 1; irq0[5] = 1; end
    settle();
    doAck(cv, co, v0, v1, vec);
    chk("R11 primary vector while cascade masked", vec, 8'h25);
    chk("R11 secondary silent on mismatch", {7'd0, v1}, 8'd0);
    rdIsr(1, v); chk("R11 secondary in-service untouched", v, 8'h00);
    eoi(0);
    @(negedge clk) begin irq1[3] = 0; irq0[5] = 0; end
    wr(0, 1, 8'h00);
    #1 chk("R4 latched cascade request raises after unmask", {7'd0, int0}, 8'd1);
    doAck(cv, co, v0, v1, vec);
    chk("R11 latched secondary vector", vec, 8'h2B);
    eoi(1); eoi(0);

    // R12: spurious acknowledge
    doAck(cv, co, v0, v1, vec);
    chk("R12 spurious vector", vec, 8'h27);
    rdIsr(0, v); chk("R12 in-service unchanged", v, 8'h00);
    rdIrr(0, v); chk("R12 request unchanged", v, 8'h00);

    // R2/R10: single mode with automatic end-of-interrupt, no cascade word
    wr(0, 0, 8'h0B);
    wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h03); wr(0, 1, 8'h40);
    @(negedge clk) irq0[6] = 1;
    settle();
    rd(0, 0, v); chk("R2 first word selects request readback", v, 8'h40);
    rd(0, 1, v); chk("R2 single mode skips cascade word", v, 8'h40);
    wr(0, 1, 8'h00);
    doAck(cv, co, v0, v1, vec);
    chk("R10 vector with auto eoi", vec, 8'h46);
    rdIsr(0, v); chk("R10 in-service stays empty", v, 8'h00);
    chk("R10 no interrupt afterwards", {7'd0, int0}, 8'd0);
    @(negedge clk) irq0[6] = 0;

    // R2/R9: level mode, no mode word
    wr(0, 0, 8'h1A); wr(0, 1, 8'h48); wr(0, 1, 8'h80);
    rd(0, 1, v); chk("R2 no mode word: next data write is mask", v, 8'h80);
    @(negedge clk) irq0[1] = 1;
    settle();
    rdIrr(0, v); chk("R9 level request visible", v, 8'h02);
    chk("R9 level raises intReq", {7'd0, int0}, 8'd1);
    @(negedge clk) irq0[1] = 0;
    settle();
    chk("R9 level drop clears intReq", {7'd0, int0}, 8'd0);
    rdIrr(0, v); chk("R9 level request follows input", v, 8'h00);
    @(negedge clk) irq0[1] = 1;
    settle();
    doAck(cv, co, v0, v1, vec);
    chk("R3 vector with second base", vec, 8'h49);
    rdIsr(0, v); chk("R8 level in-service", v, 8'h02);
    eoi(0);
    @(negedge clk) irq0[1] = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule